// File: doc/BRIEF.md
# Single-Register Raw NAND Flash Bridge

This block lets a processor drive an 8-bit asynchronous raw NAND flash device through one 32-bit register. Each register write carries a 3-bit operation code, a chip-enable flag and a data byte. The bridge turns a write into a command-latch, address-latch or data-write cycle on the flash pins. The pulse widths of the write strobe come from parameters counted in system clocks.

One operation code does not start a flash cycle. Instead it arms a read mode. While read mode is armed, every register read produces one read strobe and returns the byte sampled from the flash. Any other operation code disarms read mode. Every register read also reports the flash ready/busy line after a two-flop synchronizer.

The processor side uses a simple request/acknowledge handshake. `bus_req` is held high until `bus_ack` pulses for one cycle, so the bus stalls until the flash cycle has finished. The flash data pins are split into an output byte, an output enable and an input byte, which a pad ring combines into a tristate bus.

Top module: `nand_reg_bridge`

## Requirements
- R1: After reset, `nand_ce_n`, `nand_we_n` and `nand_re_n` are 1, `nand_cle`, `nand_ale` and `nand_io_oe` are 0, and read mode is not armed. A read issued right after reset is acknowledged on the first cycle and produces no read strobe.
- R2: A write whose bits 30:28 equal 0 produces exactly one `nand_we_n` low pulse with `nand_cle` high, `nand_ale` low and `nand_io_o` equal to write bits 23:16 at the rising edge of `nand_we_n`.
- R3: A write whose bits 30:28 equal 1 produces exactly one `nand_we_n` low pulse with `nand_ale` high, `nand_cle` low and `nand_io_o` equal to write bits 23:16.
- R4: A write whose bits 30:28 equal 3 produces exactly one `nand_we_n` low pulse carrying write bits 23:16, with both `nand_cle` and `nand_ale` low.
- R5: Write bit 31 sets the chip enable. A 1 drives `nand_ce_n` low for the cycle that the write starts. A 0 keeps it high. The value holds until the next write.
- R6: In a strobe cycle, `nand_we_n` stays low for WE_LO clocks and then high for WE_HI clocks. `nand_cle`, `nand_ale` and the driven byte hold across both phases. `bus_ack` arrives 1+WE_LO+WE_HI cycles after the request is accepted. Afterwards CLE, ALE and the bus enable are released.
- R7: A write whose bits 30:28 equal 2 arms read mode. It causes no `nand_we_n` or `nand_re_n` strobe and is acknowledged on the first cycle.
- R8: While read mode is armed, each register read drives `nand_re_n` low for RE_LO clocks and then high for RE_HI clocks. It returns, in read bits 23:16, the byte on `nand_io_i` at the end of the low phase. `bus_ack` comes 1+RE_LO+RE_HI cycles after acceptance.
- R9: A write of any operation code other than 2 (including the unused codes 4 to 7) disarms read mode. Later reads then produce no strobe, are acknowledged on the first cycle, and return the last captured byte.
- R10: Read bit 15 is 1 while `nand_rb_n` is low (busy), after two clock edges of synchronization. Read bits 31:24 and 14:0 are always 0.
- R11: `nand_cle` and `nand_ale` are never high together. `nand_io_oe` is high only during write-strobe cycles and never while `nand_re_n` is low.
- R12: `bus_ack` is a single-cycle pulse, and `nand_we_n` and `nand_re_n` are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | Register access request, held until acknowledged |
| bus_we | input | 1 | 1 for a register write, 0 for a read |
| bus_wdata | input | 32 | Register write word |
| bus_rdata | output | 32 | Register read word, valid while `bus_ack` is high |
| bus_ack | output | 1 | One-cycle completion pulse |
| nand_ce_n | output | 1 | Flash chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_io_o | output | 8 | Byte driven onto the flash I/O pins |
| nand_io_oe | output | 1 | Output enable of the flash I/O pins |
| nand_io_i | input | 8 | Byte read from the flash I/O pins |
| nand_rb_n | input | 1 | Flash ready/busy, low while busy |

## Verification
With the default timing (WE_LO=3, WE_HI=2, RE_LO=4, RE_HI=2), the acknowledge falls due 6 cycles after acceptance for command, address and data writes. It falls due 7 cycles after acceptance for armed reads, and 1 cycle after acceptance for arming, disarming and unarmed reads. The bench counts falling clock edges from the drive of the request to the acknowledge and compares that count with these figures. Strobe widths are measured by counting rising clock edges at which a strobe is sampled low. The byte and latch enables are captured at the strobe edges themselves. Busy status is checked one edge after the `nand_rb_n` change, where it must not yet show, and again two edges after, where it must.

// File: rtl/nand_bridge_pkg.sv
package nand_bridge_pkg;

    localparam int REG_W     = 32;
    localparam int BYTE_LSB  = 16;
    localparam int OPC_LSB   = 28;
    localparam int CE_BIT    = 31;
    localparam int BUSY_BIT  = 15;

    localparam logic [2:0] OPC_CMD   = 3'd0;
    localparam logic [2:0] OPC_ADDR  = 3'd1;
    localparam logic [2:0] OPC_ARM   = 3'd2;
    localparam logic [2:0] OPC_WDATA = 3'd3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WLO,
        ST_WHI,
        ST_RLO,
        ST_RHI,
        ST_DONE
    } bridge_state_e;

    typedef struct packed {
        logic       is_cmd;
        logic       is_addr;
        logic       is_arm;
        logic       is_wdata;
        logic       chip_en;
        logic [7:0] byte_val;
    } wr_decode_t;

endpackage

// File: rtl/nand_cmd_decode.sv
module nand_cmd_decode
    import nand_bridge_pkg::*;
(
    input  logic [REG_W-1:0] wdata,
    output wr_decode_t       dec
);
    logic [2:0] opc;

    always_comb begin
        opc          = wdata[OPC_LSB +: 3];
        dec.is_cmd   = (opc == OPC_CMD);
        dec.is_addr  = (opc == OPC_ADDR);
        dec.is_arm   = (opc == OPC_ARM);
        dec.is_wdata = (opc == OPC_WDATA);
        dec.chip_en  = wdata[CE_BIT];
        dec.byte_val = wdata[BYTE_LSB +: 8];
    end
endmodule

// File: rtl/nand_rb_sync.sv
module nand_rb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain_q[i] <= 1'b1;
                end else if (i == 0) begin
                    chain_q[i] <= async_in;
                end else begin
                    chain_q[i] <= chain_q[(i == 0) ? 0 : i-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/nand_reg_bridge.sv
module nand_reg_bridge
    import nand_bridge_pkg::*;
#(
    parameter int WE_LO = 3,
    parameter int WE_HI = 2,
    parameter int RE_LO = 4,
    parameter int RE_HI = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_req,
    input  logic             bus_we,
    input  logic [REG_W-1:0] bus_wdata,
    output logic [REG_W-1:0] bus_rdata,
    output logic             bus_ack,
    output logic             nand_ce_n,
    output logic             nand_cle,
    output logic             nand_ale,
    output logic             nand_we_n,
    output logic             nand_re_n,
    output logic [7:0]       nand_io_o,
    output logic             nand_io_oe,
    input  logic [7:0]       nand_io_i,
    input  logic             nand_rb_n
);
    localparam int MAX_W  = (WE_LO > WE_HI ? WE_LO : WE_HI) > (RE_LO > RE_HI ? RE_LO : RE_HI)
                          ? (WE_LO > WE_HI ? WE_LO : WE_HI) : (RE_LO > RE_HI ? RE_LO : RE_HI);
    localparam int CNT_W  = $clog2(MAX_W + 1);

    typedef struct packed {
        bridge_state_e    state;
        logic [CNT_W-1:0] cnt;
        logic             armed;
        logic             ce_n;
        logic             cle;
        logic             ale;
        logic             we_n;
        logic             re_n;
        logic             io_oe;
        logic [7:0]       io_o;
        logic [7:0]       rd_byte;
    } bridge_regs_t;

    localparam bridge_regs_t REGS_RST = '{
        state:   ST_IDLE,
        cnt:     '0,
        armed:   1'b0,
        ce_n:    1'b1,
        cle:     1'b0,
        ale:     1'b0,
        we_n:    1'b1,
        re_n:    1'b1,
        io_oe:   1'b0,
        io_o:    8'h00,
        rd_byte: 8'h00
    };

    wr_decode_t   dec;
    logic         rb_sync;
    bridge_regs_t regs_q, regs_d;

    nand_cmd_decode u_dec (
        .wdata (bus_wdata),
        .dec   (dec)
    );

    nand_rb_sync #(.STAGES(2)) u_rb_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (nand_rb_n),
        .sync_out (rb_sync)
    );

    always_comb begin
        regs_d = regs_q;
        unique case (regs_q.state)
            ST_IDLE: begin
                if (bus_req) begin
                    if (bus_we) begin
                        regs_d.ce_n = ~dec.chip_en;
                        if (dec.is_cmd || dec.is_addr || dec.is_wdata) begin
                            regs_d.armed = 1'b0;
                            regs_d.state = ST_WLO;
                            regs_d.cnt   = CNT_W'(WE_LO - 1);
                            regs_d.we_n  = 1'b0;
                            regs_d.cle   = dec.is_cmd;
                            regs_d.ale   = dec.is_addr;
                            regs_d.io_oe = 1'b1;
                            regs_d.io_o  = dec.byte_val;
                        end else begin
                            regs_d.armed = dec.is_arm;
                            regs_d.state = ST_DONE;
                        end
                    end else if (regs_q.armed) begin
                        regs_d.state = ST_RLO;
                        regs_d.cnt   = CNT_W'(RE_LO - 1);
                        regs_d.re_n  = 1'b0;
                    end else begin
                        regs_d.state = ST_DONE;
                    end
                end
            end
            ST_WLO: begin
                if (regs_q.cnt == '0) begin
                    regs_d.we_n  = 1'b1;
                    regs_d.state = ST_WHI;
                    regs_d.cnt   = CNT_W'(WE_HI - 1);
                end else begin
                    regs_d.cnt = regs_q.cnt - 1'b1;
                end
            end
            ST_WHI: begin
                if (regs_q.cnt == '0) begin
                    regs_d.cle   = 1'b0;
                    regs_d.ale   = 1'b0;
                    regs_d.io_oe = 1'b0;
                    regs_d.state = ST_DONE;
                end else begin
                    regs_d.cnt = regs_q.cnt - 1'b1;
                end
            end
            ST_RLO: begin
                if (regs_q.cnt == '0) begin
                    regs_d.re_n    = 1'b1;
                    regs_d.rd_byte = nand_io_i;
                    regs_d.state   = ST_RHI;
                    regs_d.cnt     = CNT_W'(RE_HI - 1);
                end else begin
                    regs_d.cnt = regs_q.cnt - 1'b1;
                end
            end
            ST_RHI: begin
                if (regs_q.cnt == '0) begin
                    regs_d.state = ST_DONE;
                end else begin
                    regs_d.cnt = regs_q.cnt - 1'b1;
                end
            end
            ST_DONE: regs_d.state = ST_IDLE;
            default: regs_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= REGS_RST;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        bus_rdata                     = '0;
        bus_rdata[BYTE_LSB +: 8]      = regs_q.rd_byte;
        bus_rdata[BUSY_BIT]           = ~rb_sync;
    end

    assign bus_ack    = (regs_q.state == ST_DONE);
    assign nand_ce_n  = regs_q.ce_n;
    assign nand_cle   = regs_q.cle;
    assign nand_ale   = regs_q.ale;
    assign nand_we_n  = regs_q.we_n;
    assign nand_re_n  = regs_q.re_n;
    assign nand_io_o  = regs_q.io_o;
    assign nand_io_oe = regs_q.io_oe;
endmodule

// File: rtl/nand_reg_bridge_chk.sv
module nand_reg_bridge_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] bus_rdata,
    input logic        bus_ack,
    input logic        nand_cle,
    input logic        nand_ale,
    input logic        nand_we_n,
    input logic        nand_re_n,
    input logic        nand_io_oe
);
    p_cle_ale_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(nand_cle && nand_ale));

    p_bus_off_in_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_re_n |-> !nand_io_oe);

    p_we_drives_bus_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_we_n |-> nand_io_oe);

    p_cle_drop_after_we_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(nand_cle) |-> nand_we_n);

    p_ale_drop_after_we_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(nand_ale) |-> nand_we_n);

    p_ack_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |=> !bus_ack);

    p_no_dual_strobe_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(!nand_we_n && !nand_re_n));

    p_rdata_spare_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |-> (bus_rdata[31:24] == 8'h00 && bus_rdata[14:0] == 15'h0));
endmodule

bind nand_reg_bridge nand_reg_bridge_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_rdata  (bus_rdata),
    .bus_ack    (bus_ack),
    .nand_cle   (nand_cle),
    .nand_ale   (nand_ale),
    .nand_we_n  (nand_we_n),
    .nand_re_n  (nand_re_n),
    .nand_io_oe (nand_io_oe)
);

// File: tb/nand_reg_bridge_tb.sv
`timescale 1ns/1ps
module nand_reg_bridge_tb;
    localparam int WE_LO = 3, WE_HI = 2, RE_LO = 4, RE_HI = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0, bus_we = 1'b0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic        bus_ack;
    logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_io_oe;
    logic [7:0]  nand_io_o, nand_io_i;
    logic        nand_rb_n = 1'b1;

    int tests = 0, fails = 0;
    int we_falls, re_falls, we_low, re_low, oe_in_read;
    logic cap_cle, cap_ale, cap_ce_n, cap_oe;
    logic [7:0] cap_io;
    int flash_idx = 0;

    always #5 clk = ~clk;

    nand_reg_bridge #(.WE_LO(WE_LO), .WE_HI(WE_HI), .RE_LO(RE_LO), .RE_HI(RE_HI)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
        .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
        .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_io_o(nand_io_o),
        .nand_io_oe(nand_io_oe), .nand_io_i(nand_io_i), .nand_rb_n(nand_rb_n)
    );

    function automatic logic [7:0] flash_byte(int idx);
        return 8'h3C + 8'(idx * 17);
    endfunction
    assign nand_io_i = flash_byte(flash_idx);

    always @(negedge nand_we_n) begin
        we_falls++;
        cap_cle = nand_cle; cap_ale = nand_ale; cap_ce_n = nand_ce_n;
    end
    always @(posedge nand_we_n) begin
        cap_io = nand_io_o; cap_oe = nand_io_oe;
    end
    always @(negedge nand_re_n) re_falls++;
    always @(posedge nand_re_n) if (rst_n) flash_idx++;
    always @(posedge clk) begin
        if (nand_we_n === 1'b0) we_low++;
        if (nand_re_n === 1'b0) re_low++;
        if (nand_re_n === 1'b0 && nand_io_oe === 1'b1) oe_in_read++;
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic clear_mon();
        we_falls = 0; re_falls = 0; we_low = 0; re_low = 0; oe_in_read = 0;
    endtask

    task automatic bus_access(input logic we, input logic [31:0] wd, output logic [31:0] rd, output int cyc);
        clear_mon();
        @(negedge clk);
        bus_req = 1'b1; bus_we = we; bus_wdata = wd;
        cyc = 0; rd = '0;
        for (int k = 0; k < 50; k++) begin
            @(negedge clk);
            cyc++;
            if (bus_ack) begin
                rd = bus_rdata;
                break;
            end
        end
        bus_req = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] rd; int cyc;
        check(nand_ce_n && nand_we_n && nand_re_n, "R1 strobes/ce high", {nand_ce_n, nand_we_n, nand_re_n}, 3'b111);
        check(!nand_cle && !nand_ale && !nand_io_oe, "R1 cle/ale/oe low", {nand_cle, nand_ale, nand_io_oe}, 0);
        bus_access(1'b0, 32'h0, rd, cyc);
        check(cyc == 1 && re_falls == 0, "R1 unarmed read after reset", re_falls, 0);
    endtask

    task automatic t_latch(input logic [31:0] wd, input logic exp_cle, input logic exp_ale, input string req);
        logic [31:0] rd; int cyc;
        bus_access(1'b1, wd, rd, cyc);
        check(we_falls == 1, {req, " one WE strobe"}, we_falls, 1);
        check(cap_cle == exp_cle && cap_ale == exp_ale, {req, " cle/ale"}, {cap_cle, cap_ale}, {exp_cle, exp_ale});
        check(cap_io == wd[23:16] && cap_oe, {req, " byte on bus"}, cap_io, wd[23:16]);
        check(cap_ce_n == ~wd[31], "R5 ce during cycle", cap_ce_n, ~wd[31]);
        check(cyc == 1 + WE_LO + WE_HI, "R6 ack latency", cyc, 1 + WE_LO + WE_HI);
        check(we_low == WE_LO, "R6 WE low width", we_low, WE_LO);
        check(!nand_cle && !nand_ale && !nand_io_oe, "R6 release after cycle", {nand_cle, nand_ale, nand_io_oe}, 0);
        check(nand_ce_n == ~wd[31], "R5 ce holds after cycle", nand_ce_n, ~wd[31]);
        @(negedge clk);
        check(!bus_ack, "R12 ack single pulse", bus_ack, 0);
    endtask

    task automatic t_arm_read();
        logic [31:0] rd; int cyc;
        bus_access(1'b1, 32'hA000_0000, rd, cyc);
        check(cyc == 1 && we_falls == 0 && re_falls == 0, "R7 arm without strobe", {we_falls[7:0], re_falls[7:0]}, 0);
        flash_idx = 0;
        for (int n = 0; n < 3; n++) begin
            bus_access(1'b0, 32'h0, rd, cyc);
            check(re_falls == 1 && re_low == RE_LO, "R8 one RE strobe of RE_LO", re_low, RE_LO);
            check(cyc == 1 + RE_LO + RE_HI, "R8 read latency", cyc, 1 + RE_LO + RE_HI);
            check(rd[23:16] == flash_byte(n), "R8 read byte", rd[23:16], flash_byte(n));
            check(oe_in_read == 0 && we_falls == 0, "R11 bus released in read", oe_in_read, 0);
        end
    endtask

    task automatic t_disarm(input logic [31:0] wd, input string req);
        logic [31:0] rd; int cyc;
        logic [7:0] last;
        bus_access(1'b1, 32'hA000_0000, rd, cyc);
        bus_access(1'b0, 32'h0, rd, cyc);
        last = rd[23:16];
        bus_access(1'b1, wd, rd, cyc);
        bus_access(1'b0, 32'h0, rd, cyc);
        check(re_falls == 0 && cyc == 1, {req, " no RE after disarm"}, re_falls, 0);
        check(rd[23:16] == last, {req, " keeps last byte"}, rd[23:16], last);
    endtask

    task automatic t_busy();
        logic [31:0] rd; int cyc;
        @(negedge clk);
        nand_rb_n = 1'b0;
        @(negedge clk);
        check(bus_rdata[15] == 1'b0, "R10 busy not before 2 edges", bus_rdata[15], 0);
        @(negedge clk);
        check(bus_rdata[15] == 1'b1, "R10 busy after 2 edges", bus_rdata[15], 1);
        bus_access(1'b0, 32'h0, rd, cyc);
        check(rd[15] && rd[31:24] == 0 && rd[14:0] == 0, "R10 busy read word", rd, {rd[23:16], 16'h8000});
        nand_rb_n = 1'b1;
        repeat (3) @(negedge clk);
        bus_access(1'b0, 32'h0, rd, cyc);
        check(rd[15] == 1'b0, "R10 ready read", rd[15], 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        tests++; fails++;
        $display("FAIL R12 watchdog expired actual=hang expected=finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_latch(32'h8090_0000, 1'b1, 1'b0, "R2");
        t_latch(32'h9012_0000, 1'b0, 1'b1, "R3");
        t_latch(32'hB0A5_0000, 1'b0, 1'b0, "R4");
        t_latch(32'h305A_0000, 1'b0, 1'b0, "R4");
        t_arm_read();
        t_disarm(32'hF000_0000, "R9 code 7");
        t_disarm(32'h8000_0000, "R9 command");
        t_busy();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule